// File: doc/BRIEF.md
# Two-Slot Core Clock Switcher

This block sequences a change of a core clock that is fed from two configuration slots, each holding a source select and an integer divider. Exactly one slot drives the clock at any time. A bit in a select register names that slot. A change is made by filling in the slot that is not in use and then toggling the active bit, so the running clock never sees a half-written setting. The downstream glitch-free multiplexer and the PLLs are outside the block. Here they appear only as the two register outputs.

A command carries a new source select, a new core divider and a new bus-clock divider. The block takes it only while idle and performs one register write per cycle. It first loads a wait-state count. It then writes the idle slot's source and divider, and then flips the active bit. The bus divider is raised before the flip and lowered after it, so the bus clock never exceeds its limit during the switch. A one-cycle done pulse marks the end. Software can read and write both registers through a simple port while no switch is in progress.

Top module: `dual_slot_clk_switch`

## Requirements
- R1: After reset both registers are zero, so slot 0 is active, cmd_ready is 1 and done is 0.
- R2: When idle and no command is presented, a host write with reg_addr 0 replaces the control register and a host write with reg_addr 1 replaces the select register on the next edge. reg_rdata combinationally returns the register chosen by reg_addr.
- R3: A host write is dropped while a switch is in progress. It is also dropped in the cycle a command is accepted.
- R4: In the first cycle after acceptance, the value 100 is written into control bits 23:16.
- R5: When select bit 0 is 0, the command programs slot 1 (source in control bits 14:12, divider in bits 11:8) and then sets bit 0 to 1. When select bit 0 is 1, it programs slot 0 (source in bits 6:4, divider in bits 3:0) and then clears bit 0.
- R6: The idle slot's source select is written one cycle before its divider. Select bit 0 changes in the cycle after the divider write.
- R7: The bus divider is select bits 2:1. A larger new value is written after the wait-state write and before the source write. A smaller new value is written in the cycle after the flip. An equal value causes no write.
- R8: Every register bit outside the field being written keeps its value. This covers the active slot's fields and select bits 31:3.
- R9: A switch takes 4 write cycles when the bus divider is unchanged and 5 otherwise, with at most one register changing per cycle. done is high for exactly the one cycle after the last write.
- R10: cmd_ready is low from the cycle after acceptance until done. A cmd_valid held during that time starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 1 | 0 = control register, 1 = select register |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| cmd_valid | input | 1 | Switch command present |
| cmd_ready | output | 1 | Block is idle and will take a command |
| cmd_src | input | 3 | New source select |
| cmd_div | input | 4 | New core divider |
| cmd_bus_div | input | 2 | New bus-clock divider |
| done | output | 1 | One-cycle pulse after the last write of a switch |
| ctrl_q | output | 32 | Control register (slot fields, wait-state count) |
| sel_q | output | 32 | Select register (active slot, bus divider) |

## Verification
On every cycle the checker confirms several properties. The slot currently driving the clock is never written during a switch. At most one register changes per busy cycle. Select bits 31:3 hold still while busy. done is a single-cycle pulse that coincides with cmd_ready. The bench's sweeps over every source, divider and bus-divider transition add further checks that per-cycle properties cannot express. They check the exact order of the writes: wait count, bus raise, source, divider, flip, bus lower. They check that a larger bus divider is already in place at the flip and a smaller one is applied only after it. They also show that host writes and repeated commands issued mid-switch leave no trace.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
    localparam int REG_W       = 32;
    localparam int SRC_W       = 3;
    localparam int DIV_W       = 4;
    localparam int BUS_W       = 2;
    localparam int SLOT_STRIDE = 8;
    localparam int SRC_OFS     = 4;
    localparam int WAIT_LSB    = 16;
    localparam int WAIT_W      = 8;
    localparam int WAIT_VAL    = 100;
    localparam int ACT_BIT     = 0;
    localparam int BUS_LSB     = 1;
    localparam int NUM_REGS    = 2;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WAIT, ST_BUS_PRE, ST_SRC, ST_DIV, ST_FLIP, ST_BUS_POST
    } seq_state_e;

    typedef enum logic {
        REG_CTRL = 1'b0,
        REG_SEL  = 1'b1
    } reg_id_e;

    typedef struct packed {
        logic             en;
        reg_id_e          tgt;
        logic [REG_W-1:0] mask;
        logic [REG_W-1:0] val;
    } wr_op_t;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic [DIV_W-1:0] div;
        logic [BUS_W-1:0] bus;
    } cmd_t;

    function automatic int src_lsb(input logic slot);
        return slot ? (SLOT_STRIDE + SRC_OFS) : SRC_OFS;
    endfunction

    function automatic int div_lsb(input logic slot);
        return slot ? SLOT_STRIDE : 0;
    endfunction

    // Build a masked write of one field.
    function automatic wr_op_t field_op(input reg_id_e r, input int lsb,
                                        input int width, input logic [REG_W-1:0] value);
        wr_op_t           o;
        logic [REG_W-1:0] ones;
        ones   = '1;
        o.en   = 1'b1;
        o.tgt  = r;
        o.mask = (ones >> (REG_W - width)) << lsb;
        o.val  = (value << lsb) & o.mask;
        return o;
    endfunction
endpackage

// File: rtl/dsc_bus_plan.sv
module dsc_bus_plan
    import dsc_pkg::*;
(
    input  logic [BUS_W-1:0] cur_bus,
    input  logic [BUS_W-1:0] new_bus,
    output logic             raise,
    output logic             lower
);
    always_comb begin
        raise = (new_bus > cur_bus);
        lower = (new_bus < cur_bus);
    end
endmodule

// File: rtl/dsc_regs.sv
module dsc_regs
    import dsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  wr_op_t           seq_op,
    input  wr_op_t           host_op,
    input  logic             rd_addr,
    output logic [REG_W-1:0] rdata,
    output logic [REG_W-1:0] ctrl_q,
    output logic [REG_W-1:0] sel_q
);
    wr_op_t           op;
    logic [REG_W-1:0] regs_q [NUM_REGS];

    always_comb op = seq_op.en ? seq_op : host_op;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[i] <= '0;
            else if (op.en && (int'(op.tgt) == i))
                regs_q[i] <= (regs_q[i] & ~op.mask) | (op.val & op.mask);
        end
    end

    always_comb begin
        ctrl_q = regs_q[int'(REG_CTRL)];
        sel_q  = regs_q[int'(REG_SEL)];
        rdata  = rd_addr ? sel_q : ctrl_q;
    end
endmodule

// File: rtl/dsc_seq.sv
module dsc_seq
    import dsc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cmd_fire,
    input  cmd_t   cmd_in,
    input  logic   act_slot,
    input  logic   raise,
    input  logic   lower,
    output logic   busy,
    output wr_op_t op,
    output logic   done
);
    seq_state_e state_q, state_d;
    cmd_t       cmd_q;
    logic       tgt_q;
    logic       raise_q, lower_q;
    logic       last;

    always_comb begin
        state_d = state_q;
        last    = 1'b0;
        unique case (state_q)
            ST_IDLE:     if (cmd_fire) state_d = ST_WAIT;
            ST_WAIT:     state_d = raise_q ? ST_BUS_PRE : ST_SRC;
            ST_BUS_PRE:  state_d = ST_SRC;
            ST_SRC:      state_d = ST_DIV;
            ST_DIV:      state_d = ST_FLIP;
            ST_FLIP: begin
                state_d = lower_q ? ST_BUS_POST : ST_IDLE;
                last    = !lower_q;
            end
            ST_BUS_POST: begin
                state_d = ST_IDLE;
                last    = 1'b1;
            end
            default:     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        op = '0;
        unique case (state_q)
            ST_WAIT:     op = field_op(REG_CTRL, WAIT_LSB, WAIT_W, REG_W'(WAIT_VAL));
            ST_BUS_PRE,
            ST_BUS_POST: op = field_op(REG_SEL, BUS_LSB, BUS_W, REG_W'(cmd_q.bus));
            ST_SRC:      op = field_op(REG_CTRL, src_lsb(tgt_q), SRC_W, REG_W'(cmd_q.src));
            ST_DIV:      op = field_op(REG_CTRL, div_lsb(tgt_q), DIV_W, REG_W'(cmd_q.div));
            ST_FLIP:     op = field_op(REG_SEL, ACT_BIT, 1, REG_W'(tgt_q));
            default:     op = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
            cmd_q   <= '0;
            tgt_q   <= 1'b0;
            raise_q <= 1'b0;
            lower_q <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= last;
            if (cmd_fire && state_q == ST_IDLE) begin
                cmd_q   <= cmd_in;
                tgt_q   <= ~act_slot;
                raise_q <= raise;
                lower_q <= lower;
            end
        end
    end

    assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/dual_slot_clk_switch.sv
module dual_slot_clk_switch
    import dsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [SRC_W-1:0] cmd_src,
    input  logic [DIV_W-1:0] cmd_div,
    input  logic [BUS_W-1:0] cmd_bus_div,
    output logic             done,
    output logic [REG_W-1:0] ctrl_q,
    output logic [REG_W-1:0] sel_q
);
    logic   busy, cmd_fire, raise, lower;
    cmd_t   cmd_in;
    wr_op_t seq_op, host_op;

    always_comb begin
        cmd_ready    = !busy;
        cmd_fire     = cmd_valid && cmd_ready;
        cmd_in.src   = cmd_src;
        cmd_in.div   = cmd_div;
        cmd_in.bus   = cmd_bus_div;
        host_op.en   = reg_wr && cmd_ready && !cmd_valid;
        host_op.tgt  = reg_id_e'(reg_addr);
        host_op.mask = '1;
        host_op.val  = reg_wdata;
    end

    dsc_bus_plan u_plan (
        .cur_bus (sel_q[BUS_LSB +: BUS_W]),
        .new_bus (cmd_bus_div),
        .raise   (raise),
        .lower   (lower)
    );

    dsc_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .cmd_fire (cmd_fire),
        .cmd_in   (cmd_in),
        .act_slot (sel_q[ACT_BIT]),
        .raise    (raise),
        .lower    (lower),
        .busy     (busy),
        .op       (seq_op),
        .done     (done)
    );

    dsc_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .seq_op  (seq_op),
        .host_op (host_op),
        .rd_addr (reg_addr),
        .rdata   (reg_rdata),
        .ctrl_q  (ctrl_q),
        .sel_q   (sel_q)
    );
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker
    import dsc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             done,
    input logic [REG_W-1:0] ctrl_q,
    input logic [REG_W-1:0] sel_q
);
    assert_done_with_ready_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> cmd_ready);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_one_reg_per_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        !cmd_ready |=> $countones({ctrl_q != $past(ctrl_q), sel_q != $past(sel_q)}) <= 1);

    assert_active_slot_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        !cmd_ready |=> ($past(sel_q[ACT_BIT]) ? (ctrl_q[14:8] == $past(ctrl_q[14:8]))
                                               : (ctrl_q[6:0] == $past(ctrl_q[6:0]))));

    assert_sel_upper_stable_R8: assert property (@(posedge clk) disable iff (rst)
        !cmd_ready |=> $stable(sel_q[REG_W-1:3]));

    assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> !cmd_ready);
endmodule

bind dual_slot_clk_switch dsc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .done      (done),
    .ctrl_q    (ctrl_q),
    .sel_q     (sel_q)
);

// File: tb/dual_slot_clk_switch_bench.sv
module dual_slot_clk_switch_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_src = '0;
    logic [3:0]  cmd_div = '0;
    logic [1:0]  cmd_bus_div = '0;
    logic        done;
    logic [31:0] ctrl_q, sel_q;

    int total = 0;
    int bad   = 0;
    logic [31:0] e_ctrl, e_sel;

    always #2 clk = ~clk;

    dual_slot_clk_switch u_dual_slot_clk_switch (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_src(cmd_src), .cmd_div(cmd_div),
        .cmd_bus_div(cmd_bus_div), .done(done), .ctrl_q(ctrl_q), .sel_q(sel_q)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // One write cycle: advance, then compare the full register image.
    task automatic step(input string rq, input bit last);
        @(posedge clk);
        @(negedge clk);
        chk(ctrl_q == e_ctrl, rq, ctrl_q, e_ctrl);
        chk(sel_q == e_sel, rq, sel_q, e_sel);
        chk(done == last, "R9", 32'(done), 32'(last));
        chk(cmd_ready == last, "R10", 32'(cmd_ready), 32'(last));
        if (last) begin
            reg_wr    = 1'b0;
            cmd_valid = 1'b0;
        end
    endtask

    task automatic run_cmd(input logic [2:0] src, input logic [3:0] div,
                           input logic [1:0] bus, input bit noisy);
        logic       tgt;
        logic [1:0] old;
        int         lsb;
        tgt = ~e_sel[0];
        old = e_sel[2:1];
        cmd_valid   = 1'b1;
        cmd_src     = src;
        cmd_div     = div;
        cmd_bus_div = bus;
        if (noisy) begin
            reg_wr    = 1'b1;
            reg_addr  = 1'b0;
            reg_wdata = 32'hFFFF_FFFF;
        end
        @(posedge clk);
        @(negedge clk);
        if (!noisy) cmd_valid = 1'b0;
        chk(cmd_ready == 1'b0, "R10", 32'(cmd_ready), 32'd0);
        chk(ctrl_q == e_ctrl, "R3", ctrl_q, e_ctrl);
        e_ctrl[23:16] = 8'd100;
        step("R4", 1'b0);
        if (bus > old) begin
            e_sel[2:1] = bus;
            step("R7", 1'b0);
        end
        lsb = tgt ? 12 : 4;
        e_ctrl[lsb +: 3] = src;
        step("R6", 1'b0);
        lsb = tgt ? 8 : 0;
        e_ctrl[lsb +: 4] = div;
        step("R6", 1'b0);
        e_sel[0] = tgt;
        step("R5", !(bus < old));
        if (bus < old) begin
            e_sel[2:1] = bus;
            step("R7", 1'b1);
        end
        @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R9", 32'(done), 32'd0);
        chk(ctrl_q == e_ctrl && sel_q == e_sel, "R8", ctrl_q ^ e_ctrl, sel_q ^ e_sel);
    endtask

    task automatic host_write(input logic a, input logic [31:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run did not end actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(ctrl_q == 32'd0, "R1", ctrl_q, 32'd0);
        chk(sel_q == 32'd0, "R1", sel_q, 32'd0);
        chk(cmd_ready == 1'b1, "R1", 32'(cmd_ready), 32'd1);
        chk(done == 1'b0, "R1", 32'(done), 32'd0);

        e_ctrl = 32'hC3A5_9E7F;
        e_sel  = 32'h8F0F_0F08;
        host_write(1'b0, e_ctrl);
        host_write(1'b1, e_sel);
        reg_addr = 1'b0;
        #0;
        #1 chk(reg_rdata == e_ctrl, "R2", reg_rdata, e_ctrl);
        reg_addr = 1'b1;
        #1 chk(reg_rdata == e_sel, "R2", reg_rdata, e_sel);
        @(negedge clk);

        for (int b = 0; b < 4; b++)
            for (int s = 0; s < 8; s++)
                for (int d = 0; d < 16; d++)
                    run_cmd(3'(s), 4'(d), 2'((b + s + d) % 4), 1'b0);

        run_cmd(3'd5, 4'd9, 2'd3, 1'b1);
        run_cmd(3'd2, 4'd1, 2'd0, 1'b1);
        run_cmd(3'd7, 4'd15, 2'd0, 1'b1);

        reg_addr = 1'b0;
        #1 chk(reg_rdata == e_ctrl, "R2", reg_rdata, e_ctrl);
        reg_addr = 1'b1;
        #1 chk(reg_rdata == e_sel, "R2", reg_rdata, e_sel);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule